// File: doc/BRIEF.md
# Fill-Verify Memory Tester

This block runs a fixed sequence of seven fill-then-verify passes over a region of a word-addressed memory. In each pass it first writes every word of the window under test with a generated value. It then reads every word back and compares it with the same generated value. The first word that reads back wrong ends the whole run. The address, the value the block expected and the value it got are held on the outputs until the next run starts.

A run begins with a one-cycle `start` pulse while the block is idle. The `sparse_mode` input is sampled on that same cycle. In full mode the block tests the whole configured region as one window. In sparse mode it tests only two short windows in each block of the region: one at the bottom of the block and one ending at its top edge. This is a quick boot-time screen of every block boundary.

While a run is in progress, the block pulses a watchdog kick output at a fixed word interval and once after each pass that checks clean. Long fills therefore never starve a system watchdog.

Top module: `memtest_seq`

## Requirements
- R1: While reset is applied and afterwards until the first start, `busy`, `done`, `fail`, `wdog_kick` and `mem_req` are all 0.
- R2: The seven passes run in this order, where i is the word index from 0 relative to the window base. Pass 0 writes 0x00000000. Pass 1 writes 0xFFFFFFFF. Pass 2 writes 0x55555555. Pass 3 writes 0xAAAAAAAA. Pass 4 writes 1 << (i mod 32). Pass 5 writes i. Pass 6 writes the bitwise complement of i. After a clean run, each tested word therefore holds ~i.
- R3: In every pass, writes cover the whole window in ascending address order before the first read, and reads follow in ascending order. The memory returns read data on `mem_rdata` one cycle after the request (`mem_req`=1, `mem_we`=0).
- R4: At the first word whose read data differs from the generated value, the block stops issuing memory requests and skips all remaining words, passes and windows. It sets `fail` and `done`, and latches that word's address into `fail_addr`, the generated value into `fail_expect` and the read data into `fail_actual`.
- R5: `wdog_kick` is high for one cycle on each write request and each read request whose window-relative index is a multiple of KICK_EVERY. It is also high for one cycle after each pass that verifies without error.
- R6: In sparse mode (`sparse_mode`=1), the windows are tested in this order for block b = 0 up to REGION_WORDS/BLOCK_WORDS-1. First comes the window at b*BLOCK_WORDS, then the window at b*BLOCK_WORDS+BLOCK_WORDS-WIN_WORDS. Each window is WIN_WORDS long and completes all seven passes before the next window begins. No address outside these windows is accessed.
- R7: In full mode (`sparse_mode`=0), one window of REGION_WORDS words starting at word address 0 is tested.
- R8: A run that finds no error raises `done` exactly W*7*(3L+1) clock edges after the edge that samples `start`. Here W is the number of windows and L is the window length.
- R9: A `start` pulse while `busy` is 1 is ignored. A `start` while idle clears `done` and `fail`, and `busy` is 1 from the next cycle.
- R10: `done` and the latched failure outputs stay unchanged after a run ends until the next accepted `start`, and `done` is never 1 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run while idle |
| sparse_mode | input | 1 | 1 selects boundary windows, 0 the full region; sampled with start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished (clean or failed) |
| fail | output | 1 | Last run stopped on a mismatch |
| fail_addr | output | ADDR_W | Word address of the first mismatch |
| fail_expect | output | DATA_W | Generated value at the first mismatch |
| fail_actual | output | DATA_W | Read data at the first mismatch |
| wdog_kick | output | 1 | One-cycle watchdog service pulse |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read request |

## Verification
Each write costs one cycle. Each read takes two: the request cycle, and the cycle in which the returned word is compared. The one-cycle pass gap follows the last compare. This makes `done` due exactly W*7*(3L+1) edges after the start edge. The bench counts falling edges from that start edge and checks the count for every clean run. The bench samples memory requests and kicks on every falling edge between start and done, so each request and pulse is seen exactly once in the cycle it is presented. Failure outputs are checked on the falling edge where `done` first reads 1, and again several cycles later to confirm they are held.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_CHECK,
        ST_NEXT
    } mt_state_e;

    typedef logic [2:0] pass_t;

    localparam int unsigned NUM_PASSES = 7;
    localparam pass_t       LAST_PASS  = pass_t'(NUM_PASSES - 1);

endpackage

// File: rtl/mtst_pattern.sv
module mtst_pattern
    import memtest_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 26
) (
    input  pass_t              pass_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [DATA_W-1:0]  data_o
);

    localparam int unsigned SH_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] idx_ext;
    logic [DATA_W-1:0] one_hot;

    generate
        if (IDX_W >= DATA_W) begin : g_trunc
            assign idx_ext = idx_i[DATA_W-1:0];
        end else begin : g_extend
            assign idx_ext = {{(DATA_W-IDX_W){1'b0}}, idx_i};
        end
    endgenerate

    assign one_hot = {{(DATA_W-1){1'b0}}, 1'b1} << idx_ext[SH_W-1:0];

    always_comb begin
        case (pass_i)
            3'd0:    data_o = '0;
            3'd1:    data_o = '1;
            3'd2:    data_o = {(DATA_W/2){2'b01}};
            3'd3:    data_o = {(DATA_W/2){2'b10}};
            3'd4:    data_o = one_hot;
            3'd5:    data_o = idx_ext;
            3'd6:    data_o = ~idx_ext;
            default: data_o = '0;
        endcase
    end

endmodule

// File: rtl/mtst_window.sv
module mtst_window #(
    parameter int unsigned ADDR_W       = 26,
    parameter int unsigned REGION_WORDS = 1 << 24,
    parameter int unsigned BLOCK_WORDS  = 1 << 18,
    parameter int unsigned WIN_WORDS    = 512,
    parameter int unsigned WCNT_W       = 7
) (
    input  logic              sparse_i,
    input  logic [WCNT_W-1:0] win_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] last_idx_o,
    output logic              last_win_o
);

    localparam int unsigned NUM_WIN = 2 * (REGION_WORDS / BLOCK_WORDS);
    localparam logic [ADDR_W-1:0] BLK_SZ   = ADDR_W'(BLOCK_WORDS);
    localparam logic [ADDR_W-1:0] HIGH_OFS = ADDR_W'(BLOCK_WORDS - WIN_WORDS);
    localparam logic [ADDR_W-1:0] REG_LAST = ADDR_W'(REGION_WORDS - 1);
    localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'(WIN_WORDS - 1);
    localparam logic [WCNT_W-1:0] WIN_MAX  = WCNT_W'(NUM_WIN - 1);

    logic [ADDR_W-1:0] blk_base;

    assign blk_base = ADDR_W'(win_i >> 1) * BLK_SZ;

    always_comb begin
        if (sparse_i) begin
            base_o     = blk_base + (win_i[0] ? HIGH_OFS : '0);
            last_idx_o = WIN_LAST;
            last_win_o = (win_i == WIN_MAX);
        end else begin
            base_o     = '0;
            last_idx_o = REG_LAST;
            last_win_o = 1'b1;
        end
    end

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
    import memtest_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned ADDR_W       = 26,
    parameter int unsigned REGION_WORDS = 1 << 24,
    parameter int unsigned BLOCK_WORDS  = 1 << 18,
    parameter int unsigned WIN_WORDS    = 512,
    parameter int unsigned KICK_EVERY   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sparse_mode,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_expect,
    output logic [DATA_W-1:0] fail_actual,
    output logic              wdog_kick,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int unsigned NUM_WIN = 2 * (REGION_WORDS / BLOCK_WORDS);
    localparam int unsigned WCNT_W  = $clog2(NUM_WIN);
    localparam int unsigned KICK_LG = $clog2(KICK_EVERY);

    typedef struct packed {
        mt_state_e         state;
        logic              sparse;
        pass_t             pass;
        logic [WCNT_W-1:0] win;
        logic [ADDR_W-1:0] idx;
        logic              done;
        logic              fail;
        logic [ADDR_W-1:0] f_addr;
        logic [DATA_W-1:0] f_exp;
        logic [DATA_W-1:0] f_got;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [ADDR_W-1:0] win_base;
    logic [ADDR_W-1:0] last_idx;
    logic              last_win;
    logic [DATA_W-1:0] gen_data;
    logic [ADDR_W-1:0] cur_addr;
    logic              kick_slot;
    logic              accessing;

    mtst_window #(
        .ADDR_W       (ADDR_W),
        .REGION_WORDS (REGION_WORDS),
        .BLOCK_WORDS  (BLOCK_WORDS),
        .WIN_WORDS    (WIN_WORDS),
        .WCNT_W       (WCNT_W)
    ) u_window (
        .sparse_i   (r_q.sparse),
        .win_i      (r_q.win),
        .base_o     (win_base),
        .last_idx_o (last_idx),
        .last_win_o (last_win)
    );

    mtst_pattern #(
        .DATA_W (DATA_W),
        .IDX_W  (ADDR_W)
    ) u_pattern (
        .pass_i (r_q.pass),
        .idx_i  (r_q.idx),
        .data_o (gen_data)
    );

    assign cur_addr = win_base + r_q.idx;

    generate
        if (KICK_LG == 0) begin : g_kick_all
            assign kick_slot = 1'b1;
        end else begin : g_kick_mod
            assign kick_slot = (r_q.idx[KICK_LG-1:0] == '0);
        end
    endgenerate

    assign accessing = (r_q.state == ST_WRITE) || (r_q.state == ST_READ);

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state  = ST_WRITE;
                    r_d.sparse = sparse_mode;
                    r_d.pass   = '0;
                    r_d.win    = '0;
                    r_d.idx    = '0;
                    r_d.done   = 1'b0;
                    r_d.fail   = 1'b0;
                    r_d.f_addr = '0;
                    r_d.f_exp  = '0;
                    r_d.f_got  = '0;
                end
            end
            ST_WRITE: begin
                if (r_q.idx == last_idx) begin
                    r_d.idx   = '0;
                    r_d.state = ST_READ;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_READ: begin
                r_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (mem_rdata != gen_data) begin
                    r_d.state  = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.fail   = 1'b1;
                    r_d.f_addr = cur_addr;
                    r_d.f_exp  = gen_data;
                    r_d.f_got  = mem_rdata;
                end else if (r_q.idx == last_idx) begin
                    r_d.idx   = '0;
                    r_d.state = ST_NEXT;
                end else begin
                    r_d.idx   = r_q.idx + 1'b1;
                    r_d.state = ST_READ;
                end
            end
            ST_NEXT: begin
                if (r_q.pass == LAST_PASS) begin
                    if (last_win) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.win   = r_q.win + 1'b1;
                        r_d.pass  = '0;
                        r_d.state = ST_WRITE;
                    end
                end else begin
                    r_d.pass  = r_q.pass + 1'b1;
                    r_d.state = ST_WRITE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, sparse: 1'b0, pass: '0, win: '0, idx: '0,
                     done: 1'b0, fail: 1'b0, f_addr: '0, f_exp: '0, f_got: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.state != ST_IDLE);
    assign done        = r_q.done;
    assign fail        = r_q.fail;
    assign fail_addr   = r_q.f_addr;
    assign fail_expect = r_q.f_exp;
    assign fail_actual = r_q.f_got;
    assign mem_req     = accessing;
    assign mem_we      = (r_q.state == ST_WRITE);
    assign mem_addr    = cur_addr;
    assign mem_wdata   = gen_data;
    assign wdog_kick   = (accessing && kick_slot) || (r_q.state == ST_NEXT);

endmodule

// File: rtl/memtest_seq_chk.sv
module memtest_seq_chk #(
    parameter int unsigned ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic              wdog_kick,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !wdog_kick));

    // R3
    write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we)) |->
            (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R4
    fail_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R9
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fail) && $stable(fail_addr)));

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind memtest_seq memtest_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .wdog_kick (wdog_kick),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/sim_memtest_seq.sv
module sim_memtest_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 32;
    localparam int AW  = 10;
    localparam int REG = 256;
    localparam int BLK = 64;
    localparam int WIN = 8;
    localparam int KE  = 16;
    localparam int MEMSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sparse_mode = 1'b0;
    logic          busy, done, fail, wdog_kick, mem_req, mem_we;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [DW-1:0] fail_expect, fail_actual, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memtest_seq #(
        .DATA_W(DW), .ADDR_W(AW), .REGION_WORDS(REG),
        .BLOCK_WORDS(BLK), .WIN_WORDS(WIN), .KICK_EVERY(KE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sparse_mode(sparse_mode),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_expect(fail_expect), .fail_actual(fail_actual),
        .wdog_kick(wdog_kick), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_errors = 0;

    // fault model: 0 none, 1 stuck bits at one address, 2 address bit ignored
    int          f_type = 0;
    int          f_addr = 0;
    int          f_bit  = 0;
    logic [31:0] f_mask = '0;
    logic [31:0] f_val  = '0;

    logic [DW-1:0] mem     [MEMSZ];
    logic [DW-1:0] ref_mem [MEMSZ];

    function automatic int phys(input int a);
        if (f_type == 2 && ((a >> f_bit) & 1) == 1) return a & ~(1 << f_bit);
        return a;
    endfunction

    function automatic logic [31:0] stored(input int pa, input logic [31:0] v);
        if (f_type == 1 && pa == f_addr) return (v & ~f_mask) | (f_val & f_mask);
        return v;
    endfunction

    function automatic logic [31:0] pat(input int p, input int i);
        case (p)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h5555_5555;
            3: return 32'hAAAA_AAAA;
            4: return 32'h1 << (i % 32);
            5: return 32'(i);
            default: return ~32'(i);
        endcase
    endfunction

    function automatic int win_base(input logic sp, input int w);
        if (!sp) return 0;
        return (w / 2) * BLK + (w % 2) * (BLK - WIN);
    endfunction

    function automatic logic in_window(input logic sp, input int a);
        if (!sp) return a < REG;
        return (a < REG) && ((a % BLK) < WIN || (a % BLK) >= BLK - WIN);
    endfunction

    // memory model with one cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[phys(int'(mem_addr))] <= stored(phys(int'(mem_addr)), mem_wdata);
            else        mem_rdata <= mem[phys(int'(mem_addr))];
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference expectations
    int          e_fail, e_addr, e_kicks, e_writes, e_reads, e_cycles;
    logic [31:0] e_exp, e_got;

    task automatic ref_run(input logic sp);
        int nwin = sp ? 2 * (REG / BLK) : 1;
        int len  = sp ? WIN : REG;
        e_fail = 0; e_addr = 0; e_exp = '0; e_got = '0;
        e_kicks = 0; e_writes = 0; e_reads = 0;
        e_cycles = nwin * 7 * (3 * len + 1);
        for (int a = 0; a < MEMSZ; a++) ref_mem[a] = '0;
        for (int w = 0; w < nwin; w++) begin
            for (int p = 0; p < 7; p++) begin
                for (int i = 0; i < len; i++) begin
                    int pa = phys(win_base(sp, w) + i);
                    ref_mem[pa] = stored(pa, pat(p, i));
                    e_writes++;
                    if (i % KE == 0) e_kicks++;
                end
                for (int i = 0; i < len; i++) begin
                    int a = win_base(sp, w) + i;
                    e_reads++;
                    if (i % KE == 0) e_kicks++;
                    if (ref_mem[phys(a)] != pat(p, i)) begin
                        e_fail = 1; e_addr = a; e_exp = pat(p, i); e_got = ref_mem[phys(a)];
                        return;
                    end
                end
                e_kicks++;
            end
        end
    endtask

    int m_kicks, m_writes, m_reads, m_order, m_outside, prev_kind, prev_addr;
    logic run_sp;

    task automatic sample();
        int kind = 0;
        if (wdog_kick) m_kicks++;
        if (mem_req) begin
            kind = mem_we ? 1 : 2;
            if (mem_we) m_writes++; else m_reads++;
            if (!in_window(run_sp, int'(mem_addr))) m_outside++;
            if (kind == prev_kind && int'(mem_addr) != prev_addr + 1) m_order++;
            prev_kind = kind;
            prev_addr = int'(mem_addr);
        end
    endtask

    task automatic run_test(input logic sp, input int ft, input int fa, input int fb,
                            input logic [31:0] fv, input bit intrude);
        int cnt;
        f_type = ft; f_addr = fa; f_bit = fb; f_mask = 32'h1 << fb; f_val = fv;
        run_sp = sp;
        for (int a = 0; a < MEMSZ; a++) mem[a] = '0;
        ref_run(sp);
        m_kicks = 0; m_writes = 0; m_reads = 0; m_order = 0; m_outside = 0;
        prev_kind = 0; prev_addr = 0;
        @(negedge clk);
        start = 1'b1; sparse_mode = sp;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        // R9: accepted start clears results and raises busy
        chk("R9 busy after start", 64'(busy), 64'd1);
        chk("R9 done cleared", 64'(done), 64'd0);
        chk("R9 fail cleared", 64'(fail), 64'd0);
        sample();
        while (!done) begin
            @(negedge clk);
            cnt++;
            start = (intrude && cnt == 40 && !done);
            sample();
        end
        start = 1'b0;
        chk("R4 fail flag", 64'(fail), 64'(e_fail));
        if (e_fail != 0) begin
            chk("R4 fail_addr", 64'(fail_addr), 64'(e_addr));
            chk("R4 fail_expect", 64'(fail_expect), 64'(e_exp));
            chk("R4 fail_actual", 64'(fail_actual), 64'(e_got));
        end else begin
            chk("R8 cycles to done", 64'(cnt - 1), 64'(e_cycles));
        end
        chk("R5 kick count", 64'(m_kicks), 64'(e_kicks));
        chk("R3 write count", 64'(m_writes), 64'(e_writes));
        chk("R3 read count", 64'(m_reads), 64'(e_reads));
        chk("R3 ascending order", 64'(m_order), 64'd0);
        if (sp) chk("R6 accesses inside windows", 64'(m_outside), 64'd0);
        else    chk("R7 accesses inside region", 64'(m_outside), 64'd0);
        if (ft == 0) begin
            int bad = 0;
            int nwin = sp ? 2 * (REG / BLK) : 1;
            int len  = sp ? WIN : REG;
            for (int w = 0; w < nwin; w++)
                for (int i = 0; i < len; i++)
                    if (mem[win_base(sp, w) + i] != ~32'(i)) bad++;
            chk("R2 final contents are ~index", 64'(bad), 64'd0);
        end
        begin
            logic [AW-1:0] fa_s = fail_addr;
            logic          fl_s = fail;
            repeat (5) @(negedge clk);
            chk("R10 done held", 64'(done), 64'd1);
            chk("R10 fail held", 64'(fail), 64'(fl_s));
            chk("R10 fail_addr held", 64'(fail_addr), 64'(fa_s));
            chk("R10 no request after end", 64'(mem_req), 64'd0);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy in reset", 64'(busy), 64'd0);
        chk("R1 done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 fail after reset", 64'(fail), 64'd0);
        chk("R1 kick after reset", 64'(wdog_kick), 64'd0);
        chk("R1 req after reset", 64'(mem_req), 64'd0);

        // R7 R8: full region, clean
        run_test(1'b0, 0, 0, 0, '0, 1'b0);
        // R6: sparse, clean
        run_test(1'b1, 0, 0, 0, '0, 1'b0);
        // R9: start pulses while busy are ignored
        run_test(1'b1, 0, 0, 0, '0, 1'b1);
        run_test(1'b0, 0, 0, 0, '0, 1'b1);
        // R4: stuck-at-one bit 5 at word 3 fails in the zero pass
        run_test(1'b0, 1, 3, 5, 32'hFFFF_FFFF, 1'b0);
        chk("R4 directed addr", 64'(fail_addr), 64'd3);
        chk("R4 directed got", 64'(fail_actual), 64'h20);
        // R2: address bit 4 ignored; constants pass, walking-one pass fails at word 0
        run_test(1'b0, 2, 0, 4, '0, 1'b0);
        chk("R2 alias expect", 64'(fail_expect), 64'h1);
        chk("R2 alias got", 64'(fail_actual), 64'h10000);
        // R6: fault outside every boundary window is never touched
        run_test(1'b1, 1, 100, 0, 32'hFFFF_FFFF, 1'b0);
        chk("R6 untested fault unseen", 64'(fail), 64'd0);
        // R4 R9: restart after a failure
        run_test(1'b1, 1, 127, 31, '0, 1'b0);

        for (int k = 0; k < 10; k++) begin
            logic sp = 1'($urandom % 2);
            int   ft = int'($urandom % 3);
            int   fa = int'($urandom % REG);
            int   fb = (ft == 2) ? int'($urandom % 8) : int'($urandom % 32);
            logic [31:0] fv = $urandom;
            run_test(sp, ft, fa, fb, fv, 1'($urandom % 2));
        end

        summary();
        $finish;
    end

endmodule